// File: doc/BRIEF.md
# I2C Extended Configuration Register Writer

This block is an I2C target that takes single-byte writes into a bank of three configuration registers. It samples the SCL and SDA lines on the system clock and detects start and stop conditions. It then checks the first byte against a fixed 7-bit target address combined with a write direction bit. When that byte matches, the block acknowledges the pointer byte and the data byte that follow. The pointer byte's most significant bit selects the extended register space, and its two lowest bits name the register. The data byte is committed to that register once its acknowledge bit has ended.

The register contents are plain outputs. Each register also has a one-cycle write strobe so that neighbouring logic can react to an update. None of the flows in this block can be held back. The bus side has no clock stretching, so a byte is either taken or refused at the acknowledge slot. The register side has no ready input: a strobe and its new value appear together and are never delayed. SDA is open-drain. The `sda_pull` output asks for the line to be pulled low.

Top module: `i2c_xreg_writer`

## Requirements
- R1: After reset the alert-enable register reads 0x04, the alert-threshold register reads 0xFF, the control register reads 0x00, all strobes are low and SDA is released.
- R2: A first byte other than {TGT_ADDR, 0} is not acknowledged. SDA stays released for the rest of that transaction, and no register changes until the next start.
- R3: A first byte that carries the target address with the read bit (bit 0 = 1) is not acknowledged, and nothing is stored.
- R4: After a matching address byte, the pointer byte and the data byte are both acknowledged, whatever values they hold.
- R5: A pointer byte with bit 7 = 1 and bits 1:0 = 01, 10 or 11 stores the data byte into alert-enable, alert-threshold or control respectively. Bits 6:2 are ignored.
- R6: A pointer byte with bit 7 = 0, or with bits 1:0 = 00, is acknowledged, but the data byte that follows changes no register and raises no strobe.
- R7: A data byte takes effect only after the SCL falling edge that ends its acknowledge bit. At that point exactly one strobe rises for one system clock: wr_stb[0] for alert-enable, wr_stb[1] for alert-threshold, wr_stb[2] for control.
- R8: Bytes sent after the data byte within the same transaction are not acknowledged and are not stored.
- R9: A repeated start restarts address matching from the first bit. A stop before the data byte ends the transaction, and nothing is stored.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge), 0 releases the line |
| alert_en_q | output | 8 | Alert-enable register contents |
| alert_th_q | output | 8 | Alert-threshold register contents |
| ctrl_q | output | 8 | Control register contents |
| wr_stb | output | 3 | One-cycle update strobes: bit 0 alert-enable, bit 1 alert-threshold, bit 2 control |

## Verification
The bench sweeps every pointer code, with bit 7 both clear and set. Bits 6:2 are varied, and each data value is new. This separates a correct register selection from an off-by-one mapping, from a decode that wrongly uses the middle pointer bits, and from stores caused by the unused code 00. Address bytes that differ from the target in each single bit position, plus the read-direction form, show whether the comparator uses the full byte. Trailing extra bytes, a repeated start and an early stop show whether the block leaves its write state correctly. One transfer is checked just before and just after the acknowledge bit's falling edge. This separates a commit made at the acknowledge from one made too early.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_XREG = 3;
  localparam int SEL_W    = 2;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_SKIP
  } xfer_phase_e;

  // Reset image of each extended register, index = pointer code - 1
  function automatic logic [BYTE_W-1:0] xreg_reset(input int idx);
    case (idx)
      0:       return 8'h04;
      1:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R9
  bus_event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !stop_det);
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import xreg_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_req,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BYTE_W-1:0] wr_data
);
  xfer_phase_e       phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, ptr_q;
  logic              ack_on, want_ack, ptr_ok, in_byte;

  assign want_ack = (phase != PH_ADDR) || (shreg == {TGT_ADDR, 1'b0});
  assign ptr_ok   = ptr_q[BYTE_W-1] && (ptr_q[SEL_W-1:0] != '0);
  assign in_byte  = (phase == PH_ADDR) || (phase == PH_PTR) || (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr_q   <= '0;
      ack_on  <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        ack_on  <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        ack_on  <= 1'b0;
      end else if (in_byte) begin
        if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
          if (!ack_on) begin
            if (want_ack) ack_on <= 1'b1;
            else          phase  <= PH_SKIP;
          end else begin
            ack_on  <= 1'b0;
            bit_cnt <= '0;
            case (phase)
              PH_ADDR: phase <= PH_PTR;
              PH_PTR: begin
                ptr_q <= shreg;
                phase <= PH_DATA;
              end
              default: begin
                phase   <= PH_SKIP;
                wr_req  <= ptr_ok;
                wr_data <= shreg;
              end
            endcase
          end
        end
      end
    end
  end

  assign sda_pull = ack_on;
  assign wr_sel   = ptr_q[SEL_W-1:0];

  // R10
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull));
  // R7
  commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($past(sda_pull) && !sda_pull));
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_pull);
endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
  import xreg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_req,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [BYTE_W-1:0]                wr_data,
  output logic [NUM_XREG-1:0][BYTE_W-1:0]  reg_q,
  output logic [NUM_XREG-1:0]              wr_stb
);
  for (genvar gi = 0; gi < NUM_XREG; gi++) begin : g_reg
    logic hit;
    assign hit = wr_req && (wr_sel == SEL_W'(gi + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[gi]  <= xreg_reset(gi);
        wr_stb[gi] <= 1'b0;
      end else begin
        wr_stb[gi] <= hit;
        if (hit) reg_q[gi] <= wr_data;
      end
    end

    // R5
    hold_unless_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb[gi] |-> $stable(reg_q[gi]));
  end

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
endmodule

// File: rtl/i2c_xreg_writer.sv
module i2c_xreg_writer
  import xreg_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h4A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull,
  output logic [BYTE_W-1:0]   alert_en_q,
  output logic [BYTE_W-1:0]   alert_th_q,
  output logic [BYTE_W-1:0]   ctrl_q,
  output logic [NUM_XREG-1:0] wr_stb
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_req;
  logic [SEL_W-1:0]  wr_sel;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_XREG-1:0][BYTE_W-1:0] reg_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_xfer_ctrl #(.TGT_ADDR(TGT_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull), .wr_req(wr_req), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  xreg_bank bank_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_sel(wr_sel),
    .wr_data(wr_data), .reg_q(reg_q), .wr_stb(wr_stb)
  );

  assign alert_en_q = reg_q[0];
  assign alert_th_q = reg_q[1];
  assign ctrl_q     = reg_q[2];

  // R9
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

// File: tb/i2c_xreg_writer_tb_top.sv
module i2c_xreg_writer_tb_top;
  localparam logic [6:0] ADDR = 7'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] alert_en_q, alert_th_q, ctrl_q;
  logic [2:0] wr_stb;
  wire  sda_line = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_xreg_writer #(.TGT_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .alert_en_q(alert_en_q), .alert_th_q(alert_th_q),
    .ctrl_q(ctrl_q), .wr_stb(wr_stb)
  );

  int n_chk = 0;
  int n_fail = 0;
  int stb_hi [3] = '{0, 0, 0};
  int stb_pulse [3] = '{0, 0, 0};
  int sda_viol = 0;
  logic [2:0] stb_prev = '0;
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;
  logic [7:0] exp_reg [3];
  bit done = 0;

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (wr_stb[i]) stb_hi[i]++;
      if (wr_stb[i] && !stb_prev[i]) stb_pulse[i]++;
    end
    stb_prev <= wr_stb;
    if (rst_n && scl_m && prev_scl && (sda_pull !== prev_pull)) sda_viol++;
    prev_scl  <= scl_m;
    prev_pull <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0; hold();
    end
  endtask

  task automatic ack_clock(output logic acked);
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    acked = ~sda_line;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b);
    ack_clock(acked);
    hold();
  endtask

  task automatic write_xfer(input logic [6:0] a, input logic rw, input logic [7:0] p,
                            input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({a, rw}, acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
    hold();
  endtask

  task automatic check_regs(input string req);
    check(alert_en_q == exp_reg[0], req, alert_en_q, exp_reg[0]);
    check(alert_th_q == exp_reg[1], req, alert_th_q, exp_reg[1]);
    check(ctrl_q == exp_reg[2], req, ctrl_q, exp_reg[2]);
  endtask

  task automatic check_strobes(input int base_p [3], input int tgt, input string req);
    for (int i = 0; i < 3; i++) begin
      int want;
      want = (i == tgt) ? base_p[i] + 1 : base_p[i];
      check(stb_pulse[i] == want, req, stb_pulse[i], want);
      check(stb_hi[i] == stb_pulse[i], req, stb_hi[i], stb_pulse[i]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [2:0] acks;
    logic a1, a2;
    int base [3];
    int n = 0;

    exp_reg[0] = 8'h04; exp_reg[1] = 8'hFF; exp_reg[2] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold();
    // R1 reset state
    check_regs("R1");
    check(sda_pull == 1'b0, "R1 sda", sda_pull, 0);
    check(wr_stb == 3'b000, "R1 stb", wr_stb, 0);

    // R4 R5 R6 sweep: bit 7 both values, every low code, middle bits varied
    for (int b7 = 0; b7 < 2; b7++) begin
      for (int code = 0; code < 4; code++) begin
        for (int v = 0; v < 2; v++) begin
          logic [7:0] p, d;
          int tgt;
          p = {b7[0], (v == 1) ? 5'b10101 : 5'b00000, code[1:0]};
          d = 8'(37 * n + 5);
          n++;
          tgt = (b7 == 1 && code != 0) ? code - 1 : -1;
          base = stb_pulse;
          write_xfer(ADDR, 1'b0, p, d, acks);
          check(acks == 3'b111, "R4 acks", acks, 3'b111);
          if (tgt >= 0) exp_reg[tgt] = d;
          check_regs((tgt >= 0) ? "R5" : "R6");
          check_strobes(base, tgt, (tgt >= 0) ? "R7 R5" : "R6");
        end
      end
    end

    // R2 wrong addresses in each bit
    for (int k = 0; k < 7; k++) begin
      base = stb_pulse;
      write_xfer(ADDR ^ 7'(1 << k), 1'b0, 8'h81, 8'h5A, acks);
      check(acks == 3'b000, "R2 acks", acks, 0);
      check_regs("R2");
      check_strobes(base, -1, "R2");
    end

    // R3 read direction
    base = stb_pulse;
    write_xfer(ADDR, 1'b1, 8'h82, 8'h12, acks);
    check(acks == 3'b000, "R3 acks", acks, 0);
    check_regs("R3");
    check_strobes(base, -1, "R3");

    // R8 trailing byte ignored
    base = stb_pulse;
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(8'h82, acks[1]);
    send_byte(8'h6B, acks[0]);
    send_byte(8'h33, a1);
    bus_stop(); hold();
    exp_reg[1] = 8'h6B;
    check(acks == 3'b111, "R8 acks", acks, 3'b111);
    check(a1 == 1'b0, "R8 extra ack", a1, 0);
    check_regs("R8");
    check_strobes(base, 1, "R8");

    // R9 repeated start redirects the write
    base = stb_pulse;
    bus_start();
    send_byte({ADDR, 1'b0}, a1);
    send_byte(8'h81, a2);
    bus_start();
    send_byte({ADDR, 1'b0}, acks[2]);
    send_byte(8'h83, acks[1]);
    send_byte(8'hC4, acks[0]);
    bus_stop(); hold();
    exp_reg[2] = 8'hC4;
    check(acks == 3'b111, "R9 restart acks", acks, 3'b111);
    check_regs("R9 restart");
    check_strobes(base, 2, "R9 restart");

    // R9 stop before data
    base = stb_pulse;
    bus_start();
    send_byte({ADDR, 1'b0}, a1);
    send_byte(8'h81, a2);
    bus_stop(); hold();
    check(a1 && a2, "R9 abort acks", {a1, a2}, 2'b11);
    check_regs("R9 abort");
    check_strobes(base, -1, "R9 abort");

    // R7 commit timing around the ack bit
    base = stb_pulse;
    bus_start();
    send_byte({ADDR, 1'b0}, a1);
    send_byte(8'h81, a2);
    send_bits(8'h9E);
    check(alert_en_q == exp_reg[0], "R7 before ack", alert_en_q, exp_reg[0]);
    ack_clock(a1);
    check(alert_en_q == exp_reg[0], "R7 at ack edge", alert_en_q, exp_reg[0]);
    hold();
    exp_reg[0] = 8'h9E;
    check(alert_en_q == 8'h9E, "R7 after ack", alert_en_q, 8'h9E);
    bus_stop(); hold();
    check_strobes(base, 0, "R7");

    // R10 drive changes only while SCL low
    check(sda_viol == 0, "R10", sda_viol, 0);
    finish_run();
  end
endmodule